// File: doc/BRIEF.md
# Message-Object Receive Status Tracker

This block keeps receive status for a bank of hardware message buffers that a CAN acceptance engine fills without software help. For every buffer it holds two flags. The first is an interrupt-pending flag, raised when a new frame has been completely written into that buffer. The second is an overrun flag, which records whether a new frame started landing in the buffer while the previous one was still unread.

A storage engine writes each accepted frame as a short burst of words. It announces the opening word with one strobe and the closing word with another, and both strobes carry the buffer index. Software signals that it has finished with a buffer by clearing that buffer's semaphore bits, which reaches this block as a one-cycle strobe with an index. The block combines the per-buffer enables from the surrounding register block with these events. It exposes both flag vectors and a single interrupt line that is high while any pending flag is set.

Top module: `msgobj_irq_tracker`

## Requirements
- R1: After reset every pending flag and every overrun flag is 0 and `irq_o` is 0.
- R2: A closing-word strobe for object k while `obj_ien_i[k]` is 1 sets `pend_o[k]` on the next clock edge and changes no other pending flag.
- R3: A closing-word strobe for object k while `obj_ien_i[k]` is 0 leaves all pending flags unchanged.
- R4: An opening-word strobe never changes any pending flag.
- R5: A semaphore-clear strobe for object k clears `pend_o[k]` on the next clock edge and leaves all other pending flags unchanged.
- R6: When a closing-word strobe with the enable set and a semaphore-clear strobe hit the same object in the same cycle, that object's pending flag ends up set.
- R7: An opening-word strobe for object k while `pend_o[k]` is 1 sets `lost_o[k]` on the next clock edge.
- R8: An opening-word strobe for object k while `pend_o[k]` is 0 clears `lost_o[k]` on the next clock edge.
- R9: Overrun flags change only on opening-word strobes for their own object. A closing-word strobe or a semaphore clear leaves them unchanged.
- R10: `irq_o` is 1 exactly when at least one bit of `pend_o` is 1, with no added cycle of delay.
- R11: Object indices 0 through NUM_OBJ-1 (0 to 63 by default) each address their own flag pair. Bit k of each status vector belongs to object k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| store_first_i | input | 1 | Storage engine writes the opening word of a frame |
| store_last_i | input | 1 | Storage engine writes the closing word of a frame |
| store_idx_i | input | IDX_W (6) | Object index of the storage write |
| sem_clr_i | input | 1 | Software cleared an object's semaphore bits |
| sem_idx_i | input | IDX_W (6) | Object index of the semaphore clear |
| obj_ien_i | input | NUM_OBJ (64) | Per-object interrupt enables |
| pend_o | output | NUM_OBJ (64) | Interrupt-pending flags, bit k is object k |
| lost_o | output | NUM_OBJ (64) | Overrun flags, bit k is object k |
| irq_o | output | 1 | OR of all pending flags |

## Verification
The assertions assume that each strobe lasts one cycle and that its index is in range. They also assume that only one storage burst is in flight at a time, so the opening and closing strobes of different objects never interleave in a way that would matter. The enable vector is taken as stable for the duration of a burst. The directed tasks drive each strobe for exactly one clock period at the falling edge and use only indices 0 to 63. They change `obj_ien_i` only between bursts, and they pair an opening and a closing strobe in the same cycle only to model a one-word frame.

// File: rtl/msgobj_trk_pkg.sv
package msgobj_trk_pkg;

   // Selects how the per-object pending flags are folded into one line.
   typedef enum logic {
      RED_FLAT = 1'b0,
      RED_TREE = 1'b1
   } red_style_e;

   localparam int unsigned MAX_OBJ = 1024;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/msgobj_idx_dec.sv
// Turns a strobe plus object index into a one-hot select vector.
module msgobj_idx_dec #(
   parameter int unsigned NUM_OBJ = 64,
   parameter int unsigned IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stb_i,
   input  logic [IDX_W-1:0]   idx_i,
   output logic [NUM_OBJ-1:0] sel_o
);

   if ((1 << IDX_W) < NUM_OBJ) begin : g_bad_width
      $error("msgobj_idx_dec: IDX_W too narrow for NUM_OBJ");
   end

   for (genvar i = 0; i < NUM_OBJ; i++) begin : g_sel
      assign sel_o[i] = stb_i && (idx_i == IDX_W'(i));
   end

   // R11: an in-range strobe addresses exactly one object
   p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));
   p_sel_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && (int'(idx_i) < NUM_OBJ)) |-> ($countones(sel_o) == 1));

endmodule

// File: rtl/msgobj_status_cell.sv
// Pending and overrun flags of one message object.
module msgobj_status_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic first_hit_i,
   input  logic last_hit_i,
   input  logic clr_hit_i,
   input  logic ien_i,
   output logic pend_o,
   output logic lost_o
);

   logic set_req;
   assign set_req = last_hit_i && ien_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
         lost_o <= 1'b0;
      end else begin
         // overrun is judged on the opening word, against the flag as it stands
         if (first_hit_i) begin
            lost_o <= pend_o;
         end
         // a closing-word set outranks a semaphore clear in the same cycle
         if (set_req) begin
            pend_o <= 1'b1;
         end else if (clr_hit_i) begin
            pend_o <= 1'b0;
         end
      end
   end

   p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (last_hit_i && ien_i) |=> pend_o);
   p_pend_nochg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(last_hit_i && ien_i) && !clr_hit_i) |=> $stable(pend_o));
   p_first_noset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (first_hit_i && !last_hit_i && !pend_o) |=> !pend_o);
   p_pend_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit_i && !last_hit_i) |=> !pend_o);
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit_i && last_hit_i && ien_i) |=> pend_o);
   p_lost_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
      first_hit_i |=> (lost_o == $past(pend_o)));
   p_lost_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !first_hit_i |=> $stable(lost_o));

endmodule

// File: rtl/msgobj_or_reduce.sv
// Folds a flag vector into one line, flat or as a balanced tree.
module msgobj_or_reduce
   import msgobj_trk_pkg::*;
#(
   parameter int unsigned NUM_OBJ   = 64,
   parameter red_style_e  RED_STYLE = RED_TREE
) (
   input  logic [NUM_OBJ-1:0] vec_i,
   output logic               any_o
);

   localparam int unsigned LEVELS = idx_bits(NUM_OBJ);
   localparam int unsigned NPAD   = 1 << LEVELS;

   if (RED_STYLE == RED_FLAT) begin : g_flat
      assign any_o = |vec_i;
   end else begin : g_tree
      for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
         localparam int unsigned W = NPAD >> l;
         logic [W-1:0] node;
         if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_in
               if (i < NUM_OBJ) begin : g_real
                  assign node[i] = vec_i[i];
               end else begin : g_pad
                  assign node[i] = 1'b0;
               end
            end
         end else begin : g_join
            for (genvar i = 0; i < W; i++) begin : g_pair
               assign node[i] = g_lvl[l-1].node[2*i] | g_lvl[l-1].node[2*i+1];
            end
         end
      end
      assign any_o = g_lvl[LEVELS].node[0];
   end

endmodule

// File: rtl/msgobj_irq_tracker.sv
module msgobj_irq_tracker
   import msgobj_trk_pkg::*;
#(
   parameter int unsigned NUM_OBJ   = 64,
   parameter int unsigned IDX_W     = idx_bits(NUM_OBJ),
   parameter red_style_e  RED_STYLE = RED_TREE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               store_first_i,
   input  logic               store_last_i,
   input  logic [IDX_W-1:0]   store_idx_i,
   input  logic               sem_clr_i,
   input  logic [IDX_W-1:0]   sem_idx_i,
   input  logic [NUM_OBJ-1:0] obj_ien_i,
   output logic [NUM_OBJ-1:0] pend_o,
   output logic [NUM_OBJ-1:0] lost_o,
   output logic               irq_o
);

   if (NUM_OBJ < 2 || NUM_OBJ > MAX_OBJ) begin : g_bad_count
      $error("msgobj_irq_tracker: NUM_OBJ out of range");
   end
   if (IDX_W != idx_bits(NUM_OBJ)) begin : g_bad_idx
      $error("msgobj_irq_tracker: IDX_W must match NUM_OBJ");
   end

   logic [NUM_OBJ-1:0] first_sel;
   logic [NUM_OBJ-1:0] last_sel;
   logic [NUM_OBJ-1:0] clr_sel;

   msgobj_idx_dec #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_dec_first (
      .clk(clk), .rst_n(rst_n), .stb_i(store_first_i), .idx_i(store_idx_i), .sel_o(first_sel));
   msgobj_idx_dec #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_dec_last (
      .clk(clk), .rst_n(rst_n), .stb_i(store_last_i), .idx_i(store_idx_i), .sel_o(last_sel));
   msgobj_idx_dec #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_dec_clr (
      .clk(clk), .rst_n(rst_n), .stb_i(sem_clr_i), .idx_i(sem_idx_i), .sel_o(clr_sel));

   for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj
      msgobj_status_cell u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .first_hit_i (first_sel[k]),
         .last_hit_i  (last_sel[k]),
         .clr_hit_i   (clr_sel[k]),
         .ien_i       (obj_ien_i[k]),
         .pend_o      (pend_o[k]),
         .lost_o      (lost_o[k])
      );
   end

   msgobj_or_reduce #(.NUM_OBJ(NUM_OBJ), .RED_STYLE(RED_STYLE)) u_irq_or (
      .vec_i (pend_o),
      .any_o (irq_o)
   );

   // R1: flags start clear on the first cycle after reset
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (pend_o == '0 && lost_o == '0));
   // R10: interrupt line agrees with the pending vector
   p_irq_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (pend_o != '0));
   // R2: a storage burst adds at most one pending flag per cycle
   p_one_new_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(pend_o & ~$past(pend_o)) <= 1);

endmodule

// File: tb/msgobj_irq_tracker_tb.sv
module msgobj_irq_tracker_tb;

   localparam int N  = 64;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          store_first_i = 1'b0;
   logic          store_last_i = 1'b0;
   logic [IW-1:0] store_idx_i = '0;
   logic          sem_clr_i = 1'b0;
   logic [IW-1:0] sem_idx_i = '0;
   logic [N-1:0]  obj_ien_i = '1;
   logic [N-1:0]  pend_o;
   logic [N-1:0]  lost_o;
   logic          irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [N-1:0] exp_pend = '0;
   logic [N-1:0] exp_lost = '0;

   always #5 clk = ~clk;

   msgobj_irq_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .store_first_i(store_first_i), .store_last_i(store_last_i), .store_idx_i(store_idx_i),
      .sem_clr_i(sem_clr_i), .sem_idx_i(sem_idx_i), .obj_ien_i(obj_ien_i),
      .pend_o(pend_o), .lost_o(lost_o), .irq_o(irq_o));

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One cycle of strobes; shadow flags follow the requirements.
   task automatic step(input logic f, input logic l, input int s, input logic c, input int ci);
      logic [N-1:0] np, nl;
      @(negedge clk);
      store_first_i = f; store_last_i = l; store_idx_i = IW'(s);
      sem_clr_i = c; sem_idx_i = IW'(ci);
      nl = exp_lost; np = exp_pend;
      if (f) nl[s] = exp_pend[s];           // R7 / R8
      if (c) np[ci] = 1'b0;                 // R5
      if (l && obj_ien_i[s]) np[s] = 1'b1;  // R2, R6 set wins
      @(negedge clk);
      store_first_i = 1'b0; store_last_i = 1'b0; sem_clr_i = 1'b0;
      exp_pend = np; exp_lost = nl;
   endtask

   task automatic check_all(input string tag);
      check({tag, " R2/R3/R5 pend"}, pend_o, exp_pend);
      check({tag, " R7/R8/R9 lost"}, lost_o, exp_lost);
      check({tag, " R10 irq"}, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, (exp_pend != '0)});
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 pend after reset", pend_o, '0);
      check("R1 lost after reset", lost_o, '0);
      check("R1 irq after reset", {{(N-1){1'b0}}, irq_o}, '0);
   endtask

   task automatic t_normal();
      step(1, 0, 5, 0, 0);
      check("R4 first write no pend", pend_o, '0);
      step(0, 1, 5, 0, 0);
      check("R2 pend bit 5 set", pend_o, 64'h20);
      check("R10 irq high", {{(N-1){1'b0}}, irq_o}, 64'h1);
      check("R8 lost stays 0", lost_o, '0);
      step(0, 0, 0, 1, 5);
      check("R5 pend bit 5 cleared", pend_o, '0);
      check("R10 irq low", {{(N-1){1'b0}}, irq_o}, '0);
   endtask

   task automatic t_disabled();
      obj_ien_i[9] = 1'b0;
      step(1, 0, 9, 0, 0);
      step(0, 1, 9, 0, 0);
      check("R3 disabled object no pend", pend_o, '0);
      obj_ien_i[9] = 1'b1;
      check_all("disabled");
   endtask

   task automatic t_overrun();
      step(1, 1, 12, 0, 0);
      check("R2 one-word frame pend", pend_o, 64'h1000);
      step(1, 0, 12, 0, 0);
      check("R7 lost set on overrun", lost_o, 64'h1000);
      step(0, 1, 12, 0, 0);
      step(0, 1, 40, 0, 0);
      check("R9 lost unchanged by other store", lost_o, 64'h1000);
      step(0, 0, 0, 1, 12);
      check("R9 lost kept after sem clear", lost_o, 64'h1000);
      check("R5 only bit 12 cleared", pend_o, 64'h1 << 40);
      step(1, 0, 12, 0, 0);
      check("R8 lost cleared when not pending", lost_o, '0);
      step(0, 1, 12, 0, 0);
      step(0, 0, 0, 1, 12);
      step(0, 0, 0, 1, 40);
      check_all("overrun");
   endtask

   task automatic t_race();
      step(0, 1, 20, 1, 20);
      check("R6 set wins same cycle", pend_o, 64'h1 << 20);
      step(0, 1, 21, 1, 20);
      check("R5 clear other while set", pend_o, 64'h1 << 21);
      step(0, 0, 0, 1, 21);
      check_all("race");
   endtask

   task automatic t_edges();
      step(0, 1, 0, 0, 0);
      step(0, 1, 63, 0, 0);
      check("R11 objects 0 and 63 pend", pend_o, 64'h8000_0000_0000_0001);
      step(1, 0, 63, 0, 0);
      check("R11 lost only bit 63", lost_o, 64'h8000_0000_0000_0000);
      step(0, 0, 0, 1, 0);
      check("R11 clear object 0 only", pend_o, 64'h8000_0000_0000_0000);
      check("R10 irq with bit 63", {{(N-1){1'b0}}, irq_o}, 64'h1);
      for (int k = 0; k < N; k += 9) begin
         step(0, 1, k, 0, 0);
      end
      check_all("sweep R11");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal();
      t_disabled();
      t_overrun();
      t_race();
      t_edges();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule